// File: doc/BRIEF.md
# Interrupt Entry and Nesting Sequencer

This unit sits next to the fetch sequencer of a small processor and decides, at every instruction boundary, whether the next step is an ordinary fetch or an interrupt entry. Four level-sensitive request lines are latched into a pending set. Each line has a fixed priority, with line 0 the highest. Each line also has a handler start address computed from a base and a stride. On entry the unit pushes the resume PC and the accumulator onto an internal context stack. It then emits a PC load towards the handler and marks the level as in service. A return pulse pops the newest context, emits PC and accumulator loads carrying the saved values, and retires the highest-priority active level.

A mode input selects one of two disciplines. In sequential handling, nothing is entered while any handler is running, and requests wait until the return. In nested handling, a request whose line index is lower than every active level preempts the running handler. Returns unwind the handlers in last-in, first-out order. All outputs are registered, so each event is visible for exactly one cycle after the clock edge that decided it.

Top module: `irq_seq`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero after that edge. This covers the pulses, `isr_mask`, `depth`, `pc_value` and `acc_value`.
- R2: At a boundary (`insn_done`=1, `rti`=0) with no eligible pending request, `fetch_next` pulses for one cycle after that edge, and `pc_load` and `irq_enter` stay 0.
- R3: At a boundary that has an eligible request, `irq_enter` and `pc_load` pulse together. `pc_value` equals `VEC_BASE + level*VEC_STRIDE` (0x0100 + level*0x0040 by default), and `active_lvl` equals the level. The level's bit is set in `isr_mask` and `depth` rises by one.
- R4: The context saved on entry is `cur_pc` and `cur_acc` as sampled at the deciding edge. Later changes to these inputs do not alter it.
- R5: A return (`rti`=1 with `depth`>0) pulses `pc_load` and `acc_load` with the newest saved PC and accumulator. It clears the lowest-index set bit of `isr_mask` and lowers `depth` by one. When `rti` and `insn_done` are high together, the return takes precedence and no entry or fetch is decided.
- R6: With `nest_mode`=0, no entry happens while `isr_mask` is nonzero. A request raised then stays pending and is entered at the first boundary after the return.
- R7: With `nest_mode`=1, a pending line whose index is lower than every active level preempts the running handler.
- R8: In nested operation, returns resume the interrupted handlers in reverse order of entry, each with its own saved PC and accumulator.
- R9: In nested operation, a pending line whose index is equal to or higher than an active level is not entered. It stays pending until no active level blocks it.
- R10: Among eligible pending lines, the lowest index is entered first. The others stay pending.
- R11: A return while `depth`=0 is ignored. There is no load pulse, and `isr_mask` and `depth` are unchanged.
- R12: Four handlers can be nested, one per level. `depth` then reads 4, `isr_mask` reads 0xF, and `depth` always equals the number of set bits in `isr_mask`.
- R13: A request is latched into the pending set at each clock edge where its line is high. A line first raised at the boundary edge itself is not considered until the next boundary. The pending bit is cleared on entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NSRC (4) | Level-sensitive request lines, index 0 highest priority |
| nest_mode | input | 1 | 0 = sequential handling, 1 = priority nesting |
| insn_done | input | 1 | Current instruction has completed (boundary) |
| rti | input | 1 | Return-from-interrupt pulse |
| cur_pc | input | AW (16) | PC at which the interrupted stream resumes |
| cur_acc | input | DW (16) | Current accumulator value |
| fetch_next | output | 1 | Proceed with a normal fetch |
| irq_enter | output | 1 | Interrupt cycle entered |
| pc_load | output | 1 | Load `pc_value` into the PC |
| pc_value | output | AW (16) | Handler address or restored PC |
| acc_load | output | 1 | Load `acc_value` into the accumulator |
| acc_value | output | DW (16) | Restored accumulator |
| active_lvl | output | LW (2) | Highest-priority level in service |
| isr_mask | output | NSRC (4) | Levels currently in service |
| depth | output | SW (3) | Number of saved contexts |

## Verification
The assertions check properties that hold on every cycle: `depth` agrees with the population of `isr_mask`, a fetch never coincides with a load, and an entry always loads the PC. They also check that an entered level outranks every other active level, that sequential entry leaves a single level in service, and that an empty return changes nothing. Only the bench's scenarios can show the values involved. These are the handler addresses, the exact PC and accumulator restored after several nested levels, and a blocked request surviving until the return and then being entered. The scenarios also cover the one-cycle latency between a request line and its pending bit.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  // Decision taken at a clock edge
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_FETCH  = 2'd1,
    EV_ENTER  = 2'd2,
    EV_RETURN = 2'd3
  } seq_evt_t;
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NSRC = 4,
  localparam int LW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] busy,
  input  logic            nest_mode,
  output logic            hit,
  output logic [LW-1:0]   sel
);
  logic [NSRC-1:0] allow;
  logic [NSRC-1:0] elig;
  logic            seen;

  always_comb begin
    seen  = 1'b0;
    allow = '0;
    if (nest_mode) begin
      // a line is allowed only if no active level has an equal or lower index
      for (int i = 0; i < NSRC; i++) begin
        seen     = seen | busy[i];
        allow[i] = ~seen;
      end
    end else begin
      allow = (busy == '0) ? '1 : '0;
    end
    elig = pend & allow;
    hit  = |elig;
    sel  = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) sel = LW'(i);
    end
  end
endmodule

// File: rtl/ctx_stack.sv
module ctx_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 32,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int SW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  top_q,
  output logic [SW-1:0] sp
);
  logic [W-1:0]  mem [DEPTH];
  logic [SW-1:0] sp_m1;

  assign sp_m1 = sp - SW'(1);
  assign top_q = mem[sp_m1[PW-1:0]];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push && (sp != SW'(DEPTH))) mem[sp[PW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= '0;
    end else if (push && (sp != SW'(DEPTH))) begin
      sp <= sp + SW'(1);
    end else if (pop && (sp != '0)) begin
      sp <= sp_m1;
    end
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq #(
  parameter int NSRC       = 4,
  parameter int AW         = 16,
  parameter int DW         = 16,
  parameter int VEC_BASE   = 'h0100,
  parameter int VEC_STRIDE = 'h0040,
  localparam int LW = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int SW = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] irq_req,
  input  logic            nest_mode,
  input  logic            insn_done,
  input  logic            rti,
  input  logic [AW-1:0]   cur_pc,
  input  logic [DW-1:0]   cur_acc,
  output logic            fetch_next,
  output logic            irq_enter,
  output logic            pc_load,
  output logic [AW-1:0]   pc_value,
  output logic            acc_load,
  output logic [DW-1:0]   acc_value,
  output logic [LW-1:0]   active_lvl,
  output logic [NSRC-1:0] isr_mask,
  output logic [SW-1:0]   depth
);
  import irq_seq_pkg::*;

  localparam int CW = AW + DW;

  logic [NSRC-1:0] pend_q;
  logic            hit;
  logic [LW-1:0]   sel;
  seq_evt_t        evt;
  logic [NSRC-1:0] sel_vec;
  logic [NSRC-1:0] ret_bit;
  logic [NSRC-1:0] mask_after_ret;
  logic [LW-1:0]   lvl_after_ret;
  logic [CW-1:0]   top_ctx;
  logic            do_push;
  logic            do_pop;

  irq_pick #(.NSRC(NSRC)) u_pick (
    .pend      (pend_q),
    .busy      (isr_mask),
    .nest_mode (nest_mode),
    .hit       (hit),
    .sel       (sel)
  );

  ctx_stack #(.DEPTH(NSRC), .W(CW)) u_stack (
    .clk   (clk),
    .rst   (rst),
    .push  (do_push),
    .pop   (do_pop),
    .wdata ({cur_pc, cur_acc}),
    .top_q (top_ctx),
    .sp    (depth)
  );

  // event decision: a return outranks a boundary in the same cycle
  always_comb begin
    evt = EV_NONE;
    if (rti) begin
      if (depth != '0) evt = EV_RETURN;
    end else if (insn_done) begin
      evt = hit ? EV_ENTER : EV_FETCH;
    end
  end

  assign do_push = (evt == EV_ENTER);
  assign do_pop  = (evt == EV_RETURN);

  always_comb begin
    sel_vec = '0;
    sel_vec[sel] = 1'b1;
  end

  // retire the highest-priority active level on return
  always_comb begin
    ret_bit = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (isr_mask[i]) begin
        ret_bit    = '0;
        ret_bit[i] = 1'b1;
      end
    end
    mask_after_ret = isr_mask & ~ret_bit;
    lvl_after_ret  = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (mask_after_ret[i]) lvl_after_ret = LW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= '0;
      fetch_next <= 1'b0;
      irq_enter  <= 1'b0;
      pc_load    <= 1'b0;
      pc_value   <= '0;
      acc_load   <= 1'b0;
      acc_value  <= '0;
      active_lvl <= '0;
      isr_mask   <= '0;
    end else begin
      fetch_next <= 1'b0;
      irq_enter  <= 1'b0;
      pc_load    <= 1'b0;
      acc_load   <= 1'b0;
      pend_q     <= (pend_q | irq_req) & ~(do_push ? sel_vec : '0);
      case (evt)
        EV_FETCH: fetch_next <= 1'b1;
        EV_ENTER: begin
          irq_enter  <= 1'b1;
          pc_load    <= 1'b1;
          pc_value   <= AW'(VEC_BASE + VEC_STRIDE * int'(sel));
          active_lvl <= sel;
          isr_mask   <= isr_mask | sel_vec;
        end
        EV_RETURN: begin
          pc_load    <= 1'b1;
          acc_load   <= 1'b1;
          pc_value   <= top_ctx[CW-1:DW];
          acc_value  <= top_ctx[DW-1:0];
          active_lvl <= lvl_after_ret;
          isr_mask   <= mask_after_ret;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int NSRC = 4,
  localparam int LW = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int SW = $clog2(NSRC + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            nest_mode,
  input logic            rti,
  input logic            fetch_next,
  input logic            irq_enter,
  input logic            pc_load,
  input logic            acc_load,
  input logic [LW-1:0]   active_lvl,
  input logic [NSRC-1:0] isr_mask,
  input logic [SW-1:0]   depth
);
  logic [NSRC-1:0] above_lvl;
  assign above_lvl = NSRC'((1 << active_lvl) - 1);

  a_r2_fetch_no_load: assert property (@(posedge clk) disable iff (rst)
    fetch_next |-> (!pc_load && !irq_enter && !acc_load));

  a_r3_enter_loads_pc: assert property (@(posedge clk) disable iff (rst)
    irq_enter |-> (pc_load && isr_mask[active_lvl]));

  a_r5_restore_pair: assert property (@(posedge clk) disable iff (rst)
    acc_load |-> (pc_load && !irq_enter));

  a_r6_seq_single: assert property (@(posedge clk) disable iff (rst)
    (irq_enter && !$past(nest_mode)) |-> ($countones(isr_mask) == 1));

  a_r7_entered_highest: assert property (@(posedge clk) disable iff (rst)
    irq_enter |-> ((isr_mask & above_lvl) == '0));

  a_r11_empty_ret: assert property (@(posedge clk) disable iff (rst)
    (rti && depth == '0) |=> (!pc_load && !acc_load && $stable(isr_mask)));

  a_r12_depth_mask: assert property (@(posedge clk) disable iff (rst)
    $countones(isr_mask) == int'(depth));
endmodule

bind irq_seq irq_seq_chk #(.NSRC(NSRC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .nest_mode  (nest_mode),
  .rti        (rti),
  .fetch_next (fetch_next),
  .irq_enter  (irq_enter),
  .pc_load    (pc_load),
  .acc_load   (acc_load),
  .active_lvl (active_lvl),
  .isr_mask   (isr_mask),
  .depth      (depth)
);

// File: tb/irq_seq_tb.sv
module irq_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  irq_req = '0;
  logic        nest_mode = 1'b0;
  logic        insn_done = 1'b0;
  logic        rti = 1'b0;
  logic [15:0] cur_pc = '0;
  logic [15:0] cur_acc = '0;
  logic        fetch_next, irq_enter, pc_load, acc_load;
  logic [15:0] pc_value, acc_value;
  logic [1:0]  active_lvl;
  logic [3:0]  isr_mask;
  logic [2:0]  depth;

  int errs = 0;
  int nchk = 0;
  bit done = 1'b0;

  irq_seq u_dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .nest_mode(nest_mode),
    .insn_done(insn_done), .rti(rti), .cur_pc(cur_pc), .cur_acc(cur_acc),
    .fetch_next(fetch_next), .irq_enter(irq_enter), .pc_load(pc_load),
    .pc_value(pc_value), .acc_load(acc_load), .acc_value(acc_value),
    .active_lvl(active_lvl), .isr_mask(isr_mask), .depth(depth)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic raise(input logic [3:0] m);
    irq_req = m;
    step();
    irq_req = '0;
  endtask

  task automatic boundary();
    insn_done = 1'b1;
    step();
    insn_done = 1'b0;
  endtask

  task automatic do_ret();
    rti = 1'b1;
    step();
    rti = 1'b0;
  endtask

  function automatic int vec(input int lvl);
    return 'h0100 + lvl * 'h0040;
  endfunction

  task automatic expect_entry(input string req, input int lvl, input int mask, input int dep);
    boundary();
    check({req, " enter"}, irq_enter, 1);
    check({req, " pc_load"}, pc_load, 1);
    check({req, " vector"}, pc_value, vec(lvl));
    check({req, " level"}, active_lvl, lvl);
    check({req, " mask"}, isr_mask, mask);
    check({req, " depth"}, depth, dep);
  endtask

  task automatic expect_ret(input string req, input int pc, input int acc, input int mask);
    do_ret();
    check({req, " ret pc_load"}, pc_load, 1);
    check({req, " ret acc_load"}, acc_load, 1);
    check({req, " ret pc"}, pc_value, pc);
    check({req, " ret acc"}, acc_value, acc);
    check({req, " ret mask"}, isr_mask, mask);
  endtask

  task automatic t_reset();
    check("R1 fetch", fetch_next, 0);
    check("R1 enter", irq_enter, 0);
    check("R1 pc_load", pc_load, 0);
    check("R1 pc_value", pc_value, 0);
    check("R1 mask", isr_mask, 0);
    check("R1 depth", depth, 0);
  endtask

  task automatic t_idle();
    boundary();
    check("R2 fetch", fetch_next, 1);
    check("R2 no load", pc_load, 0);
    step();
    check("R2 single pulse", fetch_next, 0);
  endtask

  task automatic t_basic();
    nest_mode = 1'b0;
    cur_pc = 16'h1234; cur_acc = 16'hBEEF;
    raise(4'b0100);
    expect_entry("R3", 2, 4'b0100, 1);
    cur_pc = 16'h0190; cur_acc = 16'h5555; // R4: later values must not be saved
    step();
    expect_ret("R4 R5", 16'h1234, 16'hBEEF, 0);
    check("R5 depth", depth, 0);
  endtask

  task automatic t_sequential();
    nest_mode = 1'b0;
    cur_pc = 16'h2000; cur_acc = 16'h0011;
    raise(4'b0100);
    expect_entry("R6 first", 2, 4'b0100, 1);
    raise(4'b0001);
    boundary();
    check("R6 held enter", irq_enter, 0);
    check("R6 held fetch", fetch_next, 1);
    expect_ret("R6", 16'h2000, 16'h0011, 0);
    expect_entry("R6 after return", 0, 4'b0001, 1);
    do_ret();
  endtask

  task automatic t_nested();
    nest_mode = 1'b1;
    cur_pc = 16'h3000; cur_acc = 16'h0001;
    raise(4'b0100);
    expect_entry("R7 low", 2, 4'b0100, 1);
    cur_pc = 16'h0184; cur_acc = 16'h0002;
    raise(4'b0001);
    expect_entry("R7 preempt", 0, 4'b0101, 2);
    expect_ret("R8 inner", 16'h0184, 16'h0002, 4'b0100);
    check("R8 level", active_lvl, 2);
    expect_ret("R8 outer", 16'h3000, 16'h0001, 0);
  endtask

  task automatic t_blocked();
    nest_mode = 1'b1;
    cur_pc = 16'h4000; cur_acc = 16'h0007;
    raise(4'b0010);
    expect_entry("R9 base", 1, 4'b0010, 1);
    raise(4'b1010);
    boundary();
    check("R9 blocked", irq_enter, 0);
    check("R9 blocked fetch", fetch_next, 1);
    expect_ret("R9", 16'h4000, 16'h0007, 0);
    expect_entry("R9 equal later", 1, 4'b0010, 1);
    do_ret();
    expect_entry("R9 lower later", 3, 4'b1000, 1);
    do_ret();
  endtask

  task automatic t_priority();
    nest_mode = 1'b0;
    raise(4'b1001);
    expect_entry("R10 first", 0, 4'b0001, 1);
    do_ret();
    expect_entry("R10 second", 3, 4'b1000, 1);
    do_ret();
    boundary();
    check("R10 drained", fetch_next, 1);
  endtask

  task automatic t_empty_ret();
    do_ret();
    check("R11 no pc_load", pc_load, 0);
    check("R11 no acc_load", acc_load, 0);
    check("R11 mask", isr_mask, 0);
    check("R11 depth", depth, 0);
  endtask

  task automatic t_full();
    nest_mode = 1'b1;
    for (int k = 0; k < 4; k++) begin
      cur_pc = 16'h5000 + 16'(k);
      cur_acc = 16'h0A00 + 16'(k);
      raise(4'b1000 >> k);
      expect_entry("R12 nest", 3 - k, (4'hF << (3 - k)) & 4'hF, k + 1);
    end
    for (int k = 3; k >= 0; k--) begin
      expect_ret("R12 unwind", 16'h5000 + k, 16'h0A00 + k, (4'hF << (4 - k)) & 4'hF);
      check("R12 depth", depth, k);
    end
  endtask

  task automatic t_timing();
    nest_mode = 1'b0;
    irq_req = 4'b0010;
    insn_done = 1'b1;
    step();
    irq_req = '0;
    insn_done = 1'b0;
    check("R13 same edge not taken", irq_enter, 0);
    check("R13 same edge fetch", fetch_next, 1);
    expect_entry("R13 next boundary", 1, 4'b0010, 1);
    do_ret();
    boundary();
    check("R13 pending cleared", fetch_next, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
    end
  end

  initial begin
    step(); step(); step();
    t_reset();
    rst = 1'b0;
    step();
    t_idle();
    t_basic();
    t_sequential();
    t_nested();
    t_blocked();
    t_priority();
    t_empty_ret();
    t_full();
    t_timing();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule